// File: doc/BRIEF.md
# Critical Instruction Marking Unit

This unit sits beside the reorder buffer of an out-of-order leading core that runs in a redundant pair. It watches per-instruction pipeline events and decides which instructions count as critical. When a critical instruction retires, the unit sends its result, or its target if it is a branch, to the trailing core. The trailing core uses these forwarded values as predictions. A 4-bit mode picks one event-based heuristic at runtime, and a 4-bit threshold N tunes the counting heuristics.

Each reorder-buffer slot keeps a sticky mark bit, a mispredict bit and a branch bit. Allocation loads the slot and a flush clears its marks. Events that arrive while the instruction is in flight set the bits. Nothing leaves the unit until commit. At commit the unit reads the slot, merges in any event for the same slot in that cycle, applies the active mode, and registers the forward record. At most one instruction commits per cycle.

Top module: `crit_mark_unit`

## Requirements
- R1: After reset `fwd_valid_o` is 0.
- R2: A forward record appears exactly one cycle after a commit, with `fwd_idx_o` equal to the committed slot. Events, allocations and flushes on their own never raise `fwd_valid_o`.
- R3: Mode 1 (head-of-ROB stall) forwards an instruction that saw a stall-at-ROB-head event. Other event kinds do not mark it in this mode.
- R4: Mode 2 forwards an instruction that saw an unexecuted-at-issue-queue-head event. Mode 3 forwards an instruction that saw a frees-the-queue-head event and ignores queue-head events.
- R5: Mode 4 forwards when an event reports a wake count of at least N. Mode 5 forwards when an event reports a consumer fanout of at least N. A count of N-1 does not mark.
- R6: Mode 6 forwards every Nth committed instruction, counting all commits, and N=0 acts as N=1. Any change of `mode_i` restarts the count.
- R7: Mode 7 forwards every slot allocated as a branch or jump. Mode 9 forwards every commit.
- R8: In modes 1 to 9, a slot that saw a mispredict event is always forwarded, with `fwd_is_branch_o`=1 and the target as data. Mode 8 forwards only such slots.
- R9: Mode 0 and codes 10 to 15 forward nothing, not even mispredicted branches.
- R10: A new allocation of a slot clears its old marks. `flush_i` clears the marks of all slots.
- R11: An event on the committing slot in the commit cycle counts toward that commit's decision.
- R12: Forward data is `commit_target_i` for branch or mispredicted slots, with `fwd_is_branch_o`=1. Otherwise it is `commit_result_i`, with `fwd_is_branch_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 4 | Heuristic select (0 off, 1..9 modes, 10..15 off) |
| thresh_i | input | TH_W | Threshold N |
| flush_i | input | 1 | Clear marks of all slots |
| alloc_valid_i | input | 1 | Slot allocation strobe |
| alloc_idx_i | input | IDX_W | Allocated slot |
| alloc_branch_i | input | 1 | Allocated instruction is a branch or jump |
| evt_valid_i | input | 1 | Event strobe |
| evt_idx_i | input | IDX_W | Slot the event refers to |
| evt_rob_stall_i | input | 1 | Unexecuted at ROB head |
| evt_iq_head_i | input | 1 | Unexecuted at issue-queue head |
| evt_frees_head_i | input | 1 | Value frees the issue-queue head |
| evt_wake_cnt_i | input | CNT_W | Instructions woken |
| evt_fanout_i | input | CNT_W | In-flight consumers |
| evt_mispred_i | input | 1 | Direction, target-buffer or return-stack miss |
| commit_valid_i | input | 1 | Commit strobe |
| commit_idx_i | input | IDX_W | Committing slot |
| commit_result_i | input | XLEN | Result value |
| commit_target_i | input | XLEN | Resolved branch target |
| fwd_valid_o | output | 1 | Forward record valid |
| fwd_idx_o | output | IDX_W | Forwarded slot |
| fwd_data_o | output | XLEN | Forwarded value |
| fwd_is_branch_o | output | 1 | 1 for a branch outcome, 0 for a value |

## Verification
The hardest cases to reach are the interactions between stored marks and whatever happens in the commit cycle. These are a mark left in a slot that was later reallocated or flushed, an event that lands on the committing slot in the same cycle, and an every-N count cut short by a mode change. The bench reaches each one through directed sequences. It marks a slot, then reallocates or flushes it before commit. It drives an event and a commit on one slot in the same cycle. It commits part of a stride, toggles the mode through another value with no commits, and checks that the count restarts.

// File: rtl/crit_mark_pkg.sv
package crit_mark_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    CM_OFF       = 4'd0,
    CM_ROB_STALL = 4'd1,
    CM_IQ_HEAD   = 4'd2,
    CM_IQ_FREE   = 4'd3,
    CM_FREED_N   = 4'd4,
    CM_FANOUT_N  = 4'd5,
    CM_EVERY_N   = 4'd6,
    CM_ALL_BJ    = 4'd7,
    CM_MISP_BJ   = 4'd8,
    CM_ALL       = 4'd9
  } cm_mode_e;

  typedef struct packed {
    logic mark;
    logic misp;
    logic br;
  } cm_entry_t;

  function automatic logic mode_on(input logic [MODE_W-1:0] m);
    return (m >= 4'd1) && (m <= 4'd9);
  endfunction
endpackage

// File: rtl/crit_evt_match.sv
module crit_evt_match
  import crit_mark_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int TH_W  = 4
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [TH_W-1:0]   thresh_i,
  input  logic              rob_stall_i,
  input  logic              iq_head_i,
  input  logic              frees_head_i,
  input  logic [CNT_W-1:0]  wake_cnt_i,
  input  logic [CNT_W-1:0]  fanout_i,
  output logic              hit_o
);
  localparam int CW = (CNT_W > TH_W) ? CNT_W : TH_W;

  logic [CW-1:0] wake_x, fan_x, th_x;
  assign wake_x = CW'(wake_cnt_i);
  assign fan_x  = CW'(fanout_i);
  assign th_x   = CW'(thresh_i);

  always_comb begin
    unique case (mode_i)
      CM_ROB_STALL: hit_o = rob_stall_i;
      CM_IQ_HEAD:   hit_o = iq_head_i;
      CM_IQ_FREE:   hit_o = frees_head_i;
      CM_FREED_N:   hit_o = wake_x >= th_x;
      CM_FANOUT_N:  hit_o = fan_x >= th_x;
      default:      hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/crit_stride_cnt.sv
module crit_stride_cnt
  import crit_mark_pkg::*;
#(
  parameter int TH_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [TH_W-1:0]   thresh_i,
  input  logic              commit_i,
  output logic              hit_o
);
  logic [MODE_W-1:0] mode_q;
  logic [TH_W-1:0]   cnt_q, cur, lim;
  logic              chg;

  assign chg   = mode_i != mode_q;
  assign cur   = chg ? '0 : cnt_q;
  assign lim   = (thresh_i == '0) ? '0 : thresh_i - 1'b1;
  assign hit_o = cur >= lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_i;
      if (commit_i) cnt_q <= hit_o ? '0 : cur + 1'b1;
      else          cnt_q <= cur;
    end
  end
endmodule

// File: rtl/crit_mark_table.sv
module crit_mark_table
  import crit_mark_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             alloc_valid_i,
  input  logic [IDX_W-1:0] alloc_idx_i,
  input  logic             alloc_branch_i,
  input  logic             set_valid_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic             set_mark_i,
  input  logic             set_misp_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output cm_entry_t        rd_o
);
  cm_entry_t ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic alloc_hit, set_hit;
    assign alloc_hit = alloc_valid_i && (alloc_idx_i == IDX_W'(g));
    assign set_hit   = set_valid_i && (set_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[g] <= '0;
      end else if (alloc_hit) begin
        ent_q[g] <= '{mark: 1'b0, misp: 1'b0, br: alloc_branch_i};
      end else if (flush_i) begin
        ent_q[g].mark <= 1'b0;
        ent_q[g].misp <= 1'b0;
      end else if (set_hit) begin
        ent_q[g].mark <= ent_q[g].mark | set_mark_i;
        ent_q[g].misp <= ent_q[g].misp | set_misp_i;
      end
    end
  end

  assign rd_o = ent_q[rd_idx_i];
endmodule

// File: rtl/crit_mark_unit.sv
module crit_mark_unit
  import crit_mark_pkg::*;
#(
  parameter int ROB_DEPTH = 32,
  parameter int XLEN      = 32,
  parameter int CNT_W     = 4,
  parameter int TH_W      = 4,
  localparam int IDX_W    = $clog2(ROB_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [TH_W-1:0]   thresh_i,
  input  logic              flush_i,
  input  logic              alloc_valid_i,
  input  logic [IDX_W-1:0]  alloc_idx_i,
  input  logic              alloc_branch_i,
  input  logic              evt_valid_i,
  input  logic [IDX_W-1:0]  evt_idx_i,
  input  logic              evt_rob_stall_i,
  input  logic              evt_iq_head_i,
  input  logic              evt_frees_head_i,
  input  logic [CNT_W-1:0]  evt_wake_cnt_i,
  input  logic [CNT_W-1:0]  evt_fanout_i,
  input  logic              evt_mispred_i,
  input  logic              commit_valid_i,
  input  logic [IDX_W-1:0]  commit_idx_i,
  input  logic [XLEN-1:0]   commit_result_i,
  input  logic [XLEN-1:0]   commit_target_i,
  output logic              fwd_valid_o,
  output logic [IDX_W-1:0]  fwd_idx_o,
  output logic [XLEN-1:0]   fwd_data_o,
  output logic              fwd_is_branch_o
);
  logic      evt_hit, stride_hit, byp, mark_eff, misp_eff, take, is_br;
  cm_entry_t rd;

  crit_evt_match #(.CNT_W(CNT_W), .TH_W(TH_W)) u_match (
    .mode_i       (mode_i),
    .thresh_i     (thresh_i),
    .rob_stall_i  (evt_rob_stall_i),
    .iq_head_i    (evt_iq_head_i),
    .frees_head_i (evt_frees_head_i),
    .wake_cnt_i   (evt_wake_cnt_i),
    .fanout_i     (evt_fanout_i),
    .hit_o        (evt_hit)
  );

  crit_mark_table #(.DEPTH(ROB_DEPTH), .IDX_W(IDX_W)) u_table (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .flush_i        (flush_i),
    .alloc_valid_i  (alloc_valid_i),
    .alloc_idx_i    (alloc_idx_i),
    .alloc_branch_i (alloc_branch_i),
    .set_valid_i    (evt_valid_i && (evt_hit || evt_mispred_i)),
    .set_idx_i      (evt_idx_i),
    .set_mark_i     (evt_hit),
    .set_misp_i     (evt_mispred_i),
    .rd_idx_i       (commit_idx_i),
    .rd_o           (rd)
  );

  crit_stride_cnt #(.TH_W(TH_W)) u_stride (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_i),
    .thresh_i (thresh_i),
    .commit_i (commit_valid_i),
    .hit_o    (stride_hit)
  );

  // same-cycle event on the committing slot
  assign byp      = evt_valid_i && (evt_idx_i == commit_idx_i);
  assign mark_eff = rd.mark | (byp & evt_hit);
  assign misp_eff = rd.misp | (byp & evt_mispred_i);
  assign is_br    = rd.br | misp_eff;

  always_comb begin
    unique case (mode_i)
      CM_ROB_STALL, CM_IQ_HEAD, CM_IQ_FREE,
      CM_FREED_N, CM_FANOUT_N: take = mark_eff | misp_eff;
      CM_EVERY_N:              take = stride_hit | misp_eff;
      CM_ALL_BJ:               take = rd.br | misp_eff;
      CM_MISP_BJ:              take = misp_eff;
      CM_ALL:                  take = 1'b1;
      default:                 take = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_valid_o     <= 1'b0;
      fwd_idx_o       <= '0;
      fwd_data_o      <= '0;
      fwd_is_branch_o <= 1'b0;
    end else begin
      fwd_valid_o <= commit_valid_i && take;
      if (commit_valid_i) begin
        fwd_idx_o       <= commit_idx_i;
        fwd_data_o      <= is_br ? commit_target_i : commit_result_i;
        fwd_is_branch_o <= is_br;
      end
    end
  end
endmodule

// File: rtl/crit_mark_chk.sv
module crit_mark_chk #(
  parameter int IDX_W = 5,
  parameter int XLEN  = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       mode_i,
  input logic             evt_valid_i,
  input logic [IDX_W-1:0] evt_idx_i,
  input logic             evt_mispred_i,
  input logic             commit_valid_i,
  input logic [IDX_W-1:0] commit_idx_i,
  input logic [XLEN-1:0]  commit_target_i,
  input logic             fwd_valid_o,
  input logic [IDX_W-1:0] fwd_idx_o,
  input logic [XLEN-1:0]  fwd_data_o,
  input logic             fwd_is_branch_o
);
  // R2
  fwd_needs_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> $past(commit_valid_i));

  // R2
  fwd_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> fwd_idx_o == $past(commit_idx_i));

  // R9
  off_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_valid_i && (mode_i == 4'd0 || mode_i > 4'd9)) |=> !fwd_valid_o);

  // R7
  all_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_valid_i && mode_i == 4'd9) |=> fwd_valid_o);

  // R8 R11
  misp_same_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_valid_i && evt_valid_i && evt_idx_i == commit_idx_i && evt_mispred_i
     && mode_i >= 4'd1 && mode_i <= 4'd9) |=> (fwd_valid_o && fwd_is_branch_o));

  // R12
  branch_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_valid_o && fwd_is_branch_o) |-> fwd_data_o == $past(commit_target_i));
endmodule

bind crit_mark_unit crit_mark_chk #(.IDX_W(IDX_W), .XLEN(XLEN)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .mode_i          (mode_i),
  .evt_valid_i     (evt_valid_i),
  .evt_idx_i       (evt_idx_i),
  .evt_mispred_i   (evt_mispred_i),
  .commit_valid_i  (commit_valid_i),
  .commit_idx_i    (commit_idx_i),
  .commit_target_i (commit_target_i),
  .fwd_valid_o     (fwd_valid_o),
  .fwd_idx_o       (fwd_idx_o),
  .fwd_data_o      (fwd_data_o),
  .fwd_is_branch_o (fwd_is_branch_o)
);

// File: tb/crit_mark_unit_bench.sv
module crit_mark_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 5;
  localparam int XLEN  = 32;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [3:0] mode = '0, thresh = '0;
  logic flush = 0, a_v = 0, a_br = 0, e_v = 0, e_rs = 0, e_iq = 0, e_fh = 0, e_mp = 0, c_v = 0;
  logic [IDX_W-1:0] a_idx = '0, e_idx = '0, c_idx = '0;
  logic [3:0] e_wk = '0, e_fo = '0;
  logic [XLEN-1:0] c_res = '0, c_tgt = '0;
  logic f_v, f_br;
  logic [IDX_W-1:0] f_idx;
  logic [XLEN-1:0] f_data;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crit_mark_unit u_crit_mark_unit (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .thresh_i(thresh), .flush_i(flush),
    .alloc_valid_i(a_v), .alloc_idx_i(a_idx), .alloc_branch_i(a_br),
    .evt_valid_i(e_v), .evt_idx_i(e_idx), .evt_rob_stall_i(e_rs), .evt_iq_head_i(e_iq),
    .evt_frees_head_i(e_fh), .evt_wake_cnt_i(e_wk), .evt_fanout_i(e_fo), .evt_mispred_i(e_mp),
    .commit_valid_i(c_v), .commit_idx_i(c_idx), .commit_result_i(c_res), .commit_target_i(c_tgt),
    .fwd_valid_o(f_v), .fwd_idx_o(f_idx), .fwd_data_o(f_data), .fwd_is_branch_o(f_br));

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  task automatic chk_idle(string tag);
    total++;
    if (f_v !== 1'b0) begin
      bad++;
      $display("FAIL %s: fwd_valid=%b expected 0", tag, f_v);
    end
  endtask

  task automatic set_mode(logic [3:0] m, logic [3:0] n);
    mode = m; thresh = n;
    @(negedge clk);
  endtask

  task automatic alloc(int idx, logic br);
    a_v = 1; a_idx = IDX_W'(idx); a_br = br;
    @(negedge clk);
    a_v = 0; a_br = 0;
  endtask

  task automatic drive_evt(int idx, logic rs, logic iq, logic fh, logic [3:0] wk,
                           logic [3:0] fo, logic mp);
    e_v = 1; e_idx = IDX_W'(idx); e_rs = rs; e_iq = iq; e_fh = fh; e_wk = wk; e_fo = fo; e_mp = mp;
  endtask

  task automatic clr_evt();
    e_v = 0; e_rs = 0; e_iq = 0; e_fh = 0; e_wk = '0; e_fo = '0; e_mp = 0;
  endtask

  task automatic event_only(int idx, logic rs, logic iq, logic fh, logic [3:0] wk,
                            logic [3:0] fo, logic mp);
    drive_evt(idx, rs, iq, fh, wk, fo, mp);
    @(negedge clk);
    clr_evt();
  endtask

  // commit one slot, check the record registered at the next edge
  task automatic commit(int idx, logic exp_v, logic exp_br, string tag);
    logic [XLEN-1:0] res, tgt, exp_d;
    res = 32'hA000_0000 + 32'(idx);
    tgt = 32'hB000_0000 + 32'(idx);
    exp_d = exp_br ? tgt : res;
    c_v = 1; c_idx = IDX_W'(idx); c_res = res; c_tgt = tgt;
    @(negedge clk);
    c_v = 0;
    clr_evt();
    total++;
    if (f_v !== exp_v || (exp_v && (f_idx !== IDX_W'(idx) || f_data !== exp_d || f_br !== exp_br))) begin
      bad++;
      $display("FAIL %s: slot %0d got v=%b idx=%0d d=%h br=%b expected v=%b idx=%0d d=%h br=%b",
               tag, idx, f_v, f_idx, f_data, f_br, exp_v, idx, exp_d, exp_br);
    end
  endtask

  task automatic t_reset();
    chk_idle("R1 reset");
  endtask

  task automatic t_rob_stall();
    set_mode(4'd1, 4'd0);
    alloc(1, 0); alloc(2, 0);
    event_only(1, 1, 0, 0, 0, 0, 0);
    chk_idle("R2 event alone");
    event_only(2, 0, 1, 1, 4'd9, 4'd9, 0);
    commit(1, 1, 0, "R3 stall marked");
    commit(2, 0, 0, "R3 other events ignored");
  endtask

  task automatic t_iq();
    set_mode(4'd2, 4'd0);
    alloc(3, 0);
    event_only(3, 0, 1, 0, 0, 0, 0);
    commit(3, 1, 0, "R4 queue head");
    set_mode(4'd3, 4'd0);
    alloc(4, 0); alloc(5, 0);
    event_only(4, 0, 0, 1, 0, 0, 0);
    event_only(5, 0, 1, 0, 0, 0, 0);
    commit(4, 1, 0, "R4 frees head");
    commit(5, 0, 0, "R4 head ignored in mode 3");
  endtask

  task automatic t_thresh();
    set_mode(4'd4, 4'd3);
    alloc(6, 0); alloc(7, 0);
    event_only(6, 0, 0, 0, 4'd2, 0, 0);
    event_only(7, 0, 0, 0, 4'd3, 0, 0);
    commit(6, 0, 0, "R5 wake N-1");
    commit(7, 1, 0, "R5 wake N");
    set_mode(4'd5, 4'd2);
    alloc(8, 0); alloc(9, 0);
    event_only(8, 0, 0, 0, 0, 4'd1, 0);
    event_only(9, 0, 0, 0, 0, 4'd2, 0);
    commit(8, 0, 0, "R5 fanout N-1");
    commit(9, 1, 0, "R5 fanout N");
  endtask

  task automatic t_every();
    set_mode(4'd6, 4'd3);
    for (int i = 0; i < 6; i++) alloc(20 + i, 0);
    for (int i = 0; i < 6; i++) commit(20 + i, (i % 3) == 2, 0, "R6 every third");
    commit(20, 0, 0, "R6 partial count 1");
    commit(21, 0, 0, "R6 partial count 2");
    set_mode(4'd9, 4'd3);
    set_mode(4'd6, 4'd3);
    commit(22, 0, 0, "R6 restart after mode change");
    set_mode(4'd6, 4'd0);
    commit(23, 1, 0, "R6 N=0 as 1");
    commit(24, 1, 0, "R6 N=0 as 1 again");
  endtask

  task automatic t_bj();
    set_mode(4'd7, 4'd0);
    alloc(10, 1); alloc(11, 0);
    commit(10, 1, 1, "R7 R12 branch forwarded with target");
    commit(11, 0, 0, "R7 non-branch dropped");
    set_mode(4'd9, 4'd0);
    alloc(12, 0);
    commit(12, 1, 0, "R7 R12 all values");
  endtask

  task automatic t_misp();
    set_mode(4'd8, 4'd0);
    alloc(13, 1); alloc(14, 1);
    event_only(13, 0, 0, 0, 0, 0, 1);
    commit(13, 1, 1, "R8 mispredict mode");
    commit(14, 0, 0, "R8 good branch dropped");
    set_mode(4'd1, 4'd0);
    alloc(15, 0);
    event_only(15, 0, 0, 0, 0, 0, 1);
    commit(15, 1, 1, "R8 mispredict in stall mode");
  endtask

  task automatic t_off();
    set_mode(4'd0, 4'd0);
    alloc(16, 1);
    event_only(16, 1, 1, 1, 4'd9, 4'd9, 1);
    commit(16, 0, 0, "R9 mode off");
    set_mode(4'd12, 4'd0);
    alloc(17, 1);
    event_only(17, 1, 0, 0, 0, 0, 1);
    commit(17, 0, 0, "R9 reserved code");
  endtask

  task automatic t_clear();
    set_mode(4'd1, 4'd0);
    alloc(18, 0);
    event_only(18, 1, 0, 0, 0, 0, 0);
    alloc(18, 0);
    commit(18, 0, 0, "R10 realloc clears");
    alloc(19, 0);
    event_only(19, 1, 0, 0, 0, 0, 1);
    flush = 1;
    @(negedge clk);
    flush = 0;
    chk_idle("R2 flush alone");
    commit(19, 0, 0, "R10 flush clears");
  endtask

  task automatic t_bypass();
    set_mode(4'd1, 4'd0);
    alloc(26, 0); alloc(27, 0);
    drive_evt(26, 1, 0, 0, 0, 0, 0);
    commit(26, 1, 0, "R11 same-cycle stall");
    drive_evt(27, 0, 0, 0, 0, 0, 1);
    commit(27, 1, 1, "R11 R8 same-cycle mispredict");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_rob_stall();
    t_iq();
    t_thresh();
    t_every();
    t_bj();
    t_misp();
    t_off();
    t_clear();
    t_bypass();
    @(negedge clk);
    finish_run();
  end
endmodule